// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that spans two clock domains. Software reaches it over a simple register port on the system clock. The count itself lives on a separate slow clock, which keeps running even if the system clock stops. The port exposes four 32-bit registers. The key register sits at offset 0x0. The divider select sits at 0x4, the reload value at 0x8 and the status at 0xC. A 12-bit down-counter on the slow clock raises a reset request when it reaches zero.

Software drives the timer by writing 16-bit key codes into bits 15:0 of the key register:

- 0xCCCC starts the watchdog.
- 0xAAAA reloads the counter.
- 0x5555 opens the divider and reload registers for writing.

A write to the divider or reload register is handed into the slow domain through a toggle handshake. A status flag stays set until the slow side has taken the new value. Refresh requests cross through the same kind of handshake. A refresh that arrives while an earlier one is still crossing is held and sent afterwards, so it is never dropped.

A hardware-start input runs the watchdog from reset without any key. A debug halt input, qualified by a freeze-enable input, stops the count while the processor is halted. Once started, the watchdog can only be stopped by reset. The reset request, once raised, holds until `rst_ni` is asserted.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the registers read as follows: key (offset 0x0) reads 0, divider select (offset 0x4) reads 0, reload (offset 0x8) reads 0xFFF and status (offset 0xC) reads 0. `wdg_reset_o` is low. The key register reads 0 at all times.
- R2: Writing 0xCCCC to bits 15:0 of the key register starts the count from 0xFFF. The reset request then rises after 4095 divided-clock periods plus a handshake latency of a few slow cycles.
- R3: Until the watchdog has been started, `wdg_reset_o` stays low. A refresh key written in that state does not load the counter.
- R4: On a running watchdog, writing 0xAAAA loads the applied reload value R into the counter and restarts the divider. The reset request then follows after R×D slow cycles plus a latency of up to 8 slow cycles, where D is the divider. Refreshing more often than that keeps `wdg_reset_o` low.
- R5: With a reload value of 0, a refresh on a running watchdog raises the reset request within 8 slow cycles.
- R6: Writing 0x5555 to the key register unlocks the divider and reload registers. Writes to them while locked leave their values unchanged. Any later key write with a different value, 0xAAAA included, locks them again.
- R7: The divider select is bits 2:0 of offset 0x4. Code c selects a divide-by 4·2^c for c from 0 to 6. Code 7 selects divide-by 256.
- R8: Status bit 0 covers the divider and status bit 1 covers the reload value. Each bit is set in the cycle after an accepted write and clears within 20 system-clock cycles of that write. A write to the matching register while its bit is set is ignored.
- R9: With `hw_start_i` high, the watchdog runs from reset without the start key, and a refresh restarts it from the reload value.
- R10: While `dbg_halt_i` and `dbg_freeze_en_i` are both high, the counter holds, and a halt of F slow cycles delays the timeout by F. A halt with `dbg_freeze_en_i` low does not change the timeout.
- R11: Once high, `wdg_reset_o` stays high through refreshes until `rst_ni` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock for the register port |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| slow_clk_i | input | 1 | Independent slow clock for the counter |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register byte offset |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from the offset |
| hw_start_i | input | 1 | Run the watchdog from reset without a key |
| dbg_halt_i | input | 1 | Processor halted by a debugger |
| dbg_freeze_en_i | input | 1 | Let a debug halt freeze the counter |
| wdg_reset_o | output | 1 | Sticky reset request, slow clock domain |

## Verification
Several properties are checked on every cycle:

- The key register reads zero.
- Locked writes and writes made while busy leave the shadow registers unchanged.
- An accepted write raises its busy flag.
- The counter never rises except on a refresh, and it holds while frozen.
- The request stays low until the watchdog has started and, once raised, stays high.

The bench scenarios are what show the end-to-end timing: the timeout after start and after refresh for each divider code, the extra delay from a freeze, how fast the busy flags clear, and hardware start. Those results depend on the handshake latency across both clocks and on long counts, and no single-cycle property can show them.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int KEY_W   = 16;
  localparam int CNT_W   = 12;
  localparam int PR_W    = 3;
  localparam int NCH     = 3;

  localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;

  localparam logic [ADDR_W-1:0] OFF_KEY = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_PR  = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_RL  = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_SR  = 4'hC;

  // crossing channels
  localparam int CH_PR  = 0;
  localparam int CH_RL  = 1;
  localparam int CH_REF = 2;
endpackage

// File: rtl/wdg_sync.sv
`timescale 1ns/1ps
module wdg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/wdg_xfer.sv
`timescale 1ns/1ps
// Toggle request with returned acknowledge; busy until the far side has taken it.
module wdg_xfer #(
  parameter int STAGES = 2
) (
  input  logic src_clk_i,
  input  logic dst_clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic busy_o,
  output logic pulse_o
);
  logic req_tgl_q, req_s, ack_tgl_q, ack_s;

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni)                req_tgl_q <= 1'b0;
    else if (req_i && !busy_o)  req_tgl_q <= ~req_tgl_q;
  end

  wdg_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
    .clk_i(dst_clk_i), .rst_ni(rst_ni), .d_i(req_tgl_q), .q_o(req_s)
  );

  always_ff @(posedge dst_clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_tgl_q <= 1'b0;
    else         ack_tgl_q <= req_s;
  end

  assign pulse_o = req_s ^ ack_tgl_q;

  wdg_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
    .clk_i(src_clk_i), .rst_ni(rst_ni), .d_i(ack_tgl_q), .q_o(ack_s)
  );

  assign busy_o = req_tgl_q ^ ack_s;
endmodule

// File: rtl/wdg_regs.sv
`timescale 1ns/1ps
module wdg_regs
  import wdg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NCH-1:0]    busy_i,
  output logic [NCH-1:0]    req_o,
  output logic [PR_W-1:0]   pr_o,
  output logic [CNT_W-1:0]  rl_o,
  output logic              start_o,
  output logic              unlock_o
);
  logic [KEY_W-1:0] key_val;
  logic key_wr, pr_acc, rl_acc, refresh_hit;
  logic unlock_q, start_q, ref_pend_q;
  logic [PR_W-1:0]  pr_q;
  logic [CNT_W-1:0] rl_q;
  logic unused_wdata;

  assign key_val      = wdata_i[KEY_W-1:0];
  assign unused_wdata = ^wdata_i[DATA_W-1:KEY_W];
  assign key_wr       = we_i && (addr_i == OFF_KEY);
  assign refresh_hit  = key_wr && (key_val == KEY_REFRESH);
  assign pr_acc       = we_i && (addr_i == OFF_PR) && unlock_q && !busy_i[CH_PR];
  assign rl_acc       = we_i && (addr_i == OFF_RL) && unlock_q && !busy_i[CH_RL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q   <= 1'b0;
      start_q    <= 1'b0;
      ref_pend_q <= 1'b0;
      pr_q       <= '0;
      rl_q       <= '1;
    end else begin
      if (key_wr) unlock_q <= (key_val == KEY_UNLOCK);
      if (key_wr && (key_val == KEY_START)) start_q <= 1'b1;
      // held until the channel is free, then issued; new refreshes coalesce
      ref_pend_q <= (ref_pend_q && busy_i[CH_REF]) || refresh_hit;
      if (pr_acc) pr_q <= wdata_i[PR_W-1:0];
      if (rl_acc) rl_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    req_o         = '0;
    req_o[CH_PR]  = pr_acc;
    req_o[CH_RL]  = rl_acc;
    req_o[CH_REF] = ref_pend_q;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_PR:  rdata_o = {{(DATA_W-PR_W){1'b0}}, pr_q};
      OFF_RL:  rdata_o = {{(DATA_W-CNT_W){1'b0}}, rl_q};
      OFF_SR:  rdata_o = {{(DATA_W-2){1'b0}}, busy_i[CH_RL], busy_i[CH_PR]};
      default: rdata_o = '0;
    endcase
  end

  assign pr_o     = pr_q;
  assign rl_o     = rl_q;
  assign start_o  = start_q;
  assign unlock_o = unlock_q;
endmodule

// File: rtl/wdg_core.sv
`timescale 1ns/1ps
module wdg_core
  import wdg_pkg::*;
#(
  localparam int MAX_SHIFT = (1 << PR_W) - 2,
  localparam int PCNT_W    = MAX_SHIFT + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             frz_i,
  input  logic             ref_i,
  input  logic             pr_ld_i,
  input  logic [PR_W-1:0]  pr_i,
  input  logic             rl_ld_i,
  input  logic [CNT_W-1:0] rl_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rst_req_o
);
  logic [PR_W-1:0]   pr_s;
  logic [CNT_W-1:0]  rl_s, rl_d, cnt_q, cnt_d;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic active, tick, reload, rst_q;

  function automatic logic [PCNT_W-1:0] div_lim(input logic [PR_W-1:0] code);
    int sh;
    sh = (int'(code) > MAX_SHIFT) ? MAX_SHIFT : int'(code);
    return PCNT_W'((1 << (sh + 2)) - 1);
  endfunction

  assign active = run_i && !frz_i;
  assign reload = ref_i && run_i;
  assign tick   = active && (pcnt_q == div_lim(pr_s));
  assign rl_d   = rl_ld_i ? rl_i : rl_s;

  always_comb begin
    // a divider change restarts the divided period, so no short tick occurs
    if (pr_ld_i || reload) pcnt_d = '0;
    else if (tick)         pcnt_d = '0;
    else if (active)       pcnt_d = pcnt_q + 1'b1;
    else                   pcnt_d = pcnt_q;

    if (reload)                     cnt_d = rl_d;
    else if (tick && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                            cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pr_s   <= '0;
      rl_s   <= '1;
      pcnt_q <= '0;
      cnt_q  <= '1;
      rst_q  <= 1'b0;
    end else begin
      if (pr_ld_i) pr_s <= pr_i;
      rl_s   <= rl_d;
      pcnt_q <= pcnt_d;
      cnt_q  <= cnt_d;
      rst_q  <= rst_q || (run_i && cnt_q == '0);
    end
  end

  assign cnt_o     = cnt_q;
  assign rst_req_o = rst_q;
endmodule

// File: rtl/keyed_wdt.sv
`timescale 1ns/1ps
module keyed_wdt
  import wdg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_clk_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              hw_start_i,
  input  logic              dbg_halt_i,
  input  logic              dbg_freeze_en_i,
  output logic              wdg_reset_o
);
  logic [NCH-1:0]   req, busy, pulse;
  logic [PR_W-1:0]  pr_shadow;
  logic [CNT_W-1:0] rl_shadow, cnt;
  logic start_q, unlock, run_s, frz_s, ref_pulse;
  logic [1:0] lvl_s;

  wdg_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o), .busy_i(busy), .req_o(req),
    .pr_o(pr_shadow), .rl_o(rl_shadow), .start_o(start_q), .unlock_o(unlock)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    wdg_xfer #(.STAGES(SYNC_STAGES)) u_xfer (
      .src_clk_i(clk_i), .dst_clk_i(slow_clk_i), .rst_ni(rst_ni),
      .req_i(req[g]), .busy_o(busy[g]), .pulse_o(pulse[g])
    );
  end

  wdg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_lvl_sync (
    .clk_i(slow_clk_i), .rst_ni(rst_ni),
    .d_i({start_q | hw_start_i, dbg_halt_i & dbg_freeze_en_i}),
    .q_o(lvl_s)
  );

  assign run_s     = lvl_s[1];
  assign frz_s     = lvl_s[0];
  assign ref_pulse = pulse[CH_REF];

  wdg_core u_core (
    .clk_i(slow_clk_i), .rst_ni(rst_ni), .run_i(run_s), .frz_i(frz_s),
    .ref_i(ref_pulse), .pr_ld_i(pulse[CH_PR]), .pr_i(pr_shadow),
    .rl_ld_i(pulse[CH_RL]), .rl_i(rl_shadow), .cnt_o(cnt),
    .rst_req_o(wdg_reset_o)
  );
endmodule

// File: rtl/keyed_wdt_chk.sv
`timescale 1ns/1ps
module keyed_wdt_chk
  import wdg_pkg::*;
(
  input logic              clk_i,
  input logic              slow_clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              wdg_reset_o,
  input logic              unlock_i,
  input logic [PR_W-1:0]   pr_shadow_i,
  input logic [CNT_W-1:0]  rl_shadow_i,
  input logic [NCH-1:0]    busy_i,
  input logic              run_i,
  input logic              frz_i,
  input logic              ref_i,
  input logic [CNT_W-1:0]  cnt_i
);
  assert_key_reads_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == OFF_KEY) |-> (bus_rdata_o == '0));

  assert_locked_pr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFF_PR && !unlock_i) |=> $stable(pr_shadow_i));

  assert_locked_rl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFF_RL && !unlock_i) |=> $stable(rl_shadow_i));

  assert_busy_drop_pr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFF_PR && busy_i[CH_PR]) |=> $stable(pr_shadow_i));

  assert_busy_set_rl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFF_RL && unlock_i && !busy_i[CH_RL]) |=> busy_i[CH_RL]);

  assert_stopped_quiet_R3: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    !run_i |-> !wdg_reset_o);

  assert_sticky_request_R11: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    wdg_reset_o |=> wdg_reset_o);

  assert_freeze_holds_R10: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    (run_i && frz_i && !ref_i) |=> $stable(cnt_i));

  assert_no_count_up_R4: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    !ref_i |=> (cnt_i <= $past(cnt_i)));
endmodule

bind keyed_wdt keyed_wdt_chk u_chk (
  .clk_i(clk_i), .slow_clk_i(slow_clk_i), .rst_ni(rst_ni),
  .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o),
  .wdg_reset_o(wdg_reset_o), .unlock_i(unlock), .pr_shadow_i(pr_shadow),
  .rl_shadow_i(rl_shadow), .busy_i(busy), .run_i(run_s), .frz_i(frz_s),
  .ref_i(ref_pulse), .cnt_i(cnt)
);

// File: tb/keyed_wdt_tb.sv
`timescale 1ns/1ps
module keyed_wdt_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int SLOW_PERIOD = 30;
  localparam int WDOG_CYCLES = 190000;

  logic clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, hw_start = 1'b0, halt = 1'b0, frz_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic wdg_rst;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  keyed_wdt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .slow_clk_i(slow_clk), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .hw_start_i(hw_start), .dbg_halt_i(halt), .dbg_freeze_en_i(frz_en),
    .wdg_reset_o(wdg_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  initial begin
    #4;
    forever #(SLOW_PERIOD/2) slow_clk = ~slow_clk;
  end

  function automatic int div_of(input int code);
    return 4 << ((code > 6) ? 6 : code);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input int v, input int lo, input int hi, input string tag);
    n_chk++;
    if (v < lo || v > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, v, lo, hi);
    end
  endtask

  task automatic do_reset(input bit hw);
    rst_n = 1'b0; we = 1'b0; halt = 1'b0; frz_en = 1'b0; hw_start = hw;
    repeat (4) @(negedge slow_clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] s;
    cyc = 0;
    rd(4'hC, s);
    while (s != 0 && cyc < 200) begin
      cyc++;
      rd(4'hC, s);
    end
  endtask

  task automatic measure(input int max_n, output int n);
    n = 0;
    while (!wdg_rst && n < max_n) begin
      @(negedge slow_clk);
      n++;
    end
  endtask

  task automatic setup(input int code, input int rl);
    int c;
    wr(4'h0, 32'h5555);
    wr(4'h4, code);
    wr(4'h8, rl);
    wait_idle(c);
  endtask

  task automatic start_wdt();
    wr(4'h0, 32'hCCCC);
    repeat (4) @(negedge slow_clk);
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n, c, r, cyc, ph;
    void'($urandom(32'd7321));

    // R1 reset values
    do_reset(0);
    rd(4'h0, v); chk(v == 0, "R1 key", v, 0);
    rd(4'h4, v); chk(v == 0, "R1 prescale", v, 0);
    rd(4'h8, v); chk(v == 32'hFFF, "R1 reload", v, 32'hFFF);
    rd(4'hC, v); chk(v == 0, "R1 status", v, 0);
    chk(wdg_rst == 0, "R1 reset_o", wdg_rst, 0);

    // R6 lock sequence
    wr(4'h4, 5); rd(4'h4, v); chk(v == 0, "R6 locked pr", v, 0);
    wr(4'h8, 32'h123); rd(4'h8, v); chk(v == 32'hFFF, "R6 locked rl", v, 32'hFFF);
    wr(4'h0, 32'h5555); wr(4'h0, 32'hAAAA);
    wr(4'h4, 5); rd(4'h4, v); chk(v == 0, "R6 relock by refresh", v, 0);
    wr(4'h0, 32'h5555); wr(4'h0, 32'h1234);
    wr(4'h8, 32'h123); rd(4'h8, v); chk(v == 32'hFFF, "R6 relock by other key", v, 32'hFFF);
    wr(4'h0, 32'h5555);
    rd(4'h0, v); chk(v == 0, "R1 key after write", v, 0);
    wr(4'h8, 32'h123); rd(4'h8, v); chk(v == 32'h123, "R6 unlocked rl", v, 32'h123);
    wait_idle(cyc);

    // R8 busy flags
    do_reset(0);
    wr(4'h0, 32'h5555);
    wr(4'h4, 3);
    rd(4'hC, v); chk(v[0] == 1'b1, "R8 pr busy set", v, 1);
    wr(4'h4, 6);
    rd(4'h4, v); chk(v == 3, "R8 write while busy", v, 3);
    wait_idle(cyc); chk(cyc + 4 <= 20, "R8 pr busy clears", cyc + 4, 20);
    wr(4'h8, 32'h40);
    rd(4'hC, v); chk(v[1] == 1'b1 && v[0] == 1'b0, "R8 rl busy set", v, 2);
    wait_idle(cyc); chk(cyc + 2 <= 20, "R8 rl busy clears", cyc + 2, 20);
    rd(4'h8, v); chk(v == 32'h40, "R8 rl value", v, 32'h40);

    // R3 stopped watchdog ignores refresh
    do_reset(0);
    setup(0, 5);
    wr(4'h0, 32'hAAAA);
    repeat (300) @(negedge slow_clk);
    chk(wdg_rst == 0, "R3 stopped no request", wdg_rst, 0);

    // R2 start counts from 0xFFF at /4
    do_reset(0);
    wr(4'h0, 32'hCCCC);
    measure(17000, n);
    chk_rng(n, 4095*4, 4095*4 + 10, "R2 timeout from start");

    // R7 random divider codes and reloads
    for (int i = 0; i < 6; i++) begin
      c = $urandom % 8;
      r = 1 + ($urandom % (2048 / div_of(c)));
      do_reset(0);
      setup(c, r);
      start_wdt();
      wr(4'h0, 32'hAAAA);
      measure(r * div_of(c) + 50, n);
      chk_rng(n, r * div_of(c), r * div_of(c) + 8, "R7 R4 random timeout");
    end

    // R7 code 7 matches /256
    do_reset(0);
    setup(7, 3);
    start_wdt();
    wr(4'h0, 32'hAAAA);
    measure(900, n);
    chk_rng(n, 768, 776, "R7 code 7");

    // R4 periodic refresh keeps request low, then lapse times out
    do_reset(0);
    setup(0, 50);
    start_wdt();
    for (int i = 0; i < 10; i++) begin
      wr(4'h0, 32'hAAAA);
      wr(4'h0, 32'hAAAA);
      repeat (100) @(negedge slow_clk);
    end
    chk(wdg_rst == 0, "R4 refresh holds off", wdg_rst, 0);
    wr(4'h0, 32'hAAAA);
    measure(300, n);
    chk_rng(n, 200, 208, "R4 lapse timeout");

    // R5 reload zero, then R11 sticky
    do_reset(0);
    setup(2, 0);
    start_wdt();
    wr(4'h0, 32'hAAAA);
    measure(50, n);
    chk_rng(n, 1, 8, "R5 zero reload");
    wr(4'h0, 32'hAAAA);
    repeat (40) @(negedge slow_clk);
    chk(wdg_rst == 1, "R11 sticky after refresh", wdg_rst, 1);
    do_reset(0);
    chk(wdg_rst == 0, "R11 cleared by reset", wdg_rst, 0);

    // R10 freeze delays, halt alone does not
    for (int m = 0; m < 2; m++) begin
      do_reset(0);
      setup(0, 60);
      start_wdt();
      wr(4'h0, 32'hAAAA);
      n = 0;
      while (!wdg_rst && n < 600) begin
        @(negedge slow_clk);
        n++;
        if (n == 20)  begin halt = 1'b1; frz_en = (m == 0); end
        if (n == 120) begin halt = 1'b0; frz_en = 1'b0; end
      end
      ph = (m == 0) ? 100 : 0;
      chk_rng(n, 240 + ph, 240 + ph + 10, (m == 0) ? "R10 frozen" : "R10 halt no freeze");
    end

    // R9 hardware start
    do_reset(1);
    setup(0, 30);
    wr(4'h0, 32'hAAAA);
    measure(400, n);
    chk_rng(n, 120, 128, "R9 hardware start");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule